// File: doc/BRIEF.md
# Threshold Cluster Finder with Sparse Readout

This block searches a stream of pixel rows for clusters of charge and passes on only the pixels around them. On each row cycle it takes one 5-bit sample for every column at once. It keeps the last four rows and, for every 2×2 group of neighbouring pixels, adds the four samples and compares the sum with one threshold that applies to the whole array. A sum above the threshold marks every pixel within three rows and three columns of the group's top-left pixel. Once no later group can mark a row any more, that row is scanned. Each marked pixel becomes one word holding its row, its column and its sample, and the word goes into an output FIFO that a downstream reader drains with a valid/ready handshake.

A frame has `NROWS` rows, numbered from 0 after reset. After the last row of a frame, the block finishes its last four rows without any further input. Input rows that arrive during this short tail are ignored, so the source leaves a gap between frames. The scanner writes one word per cycle. The source must therefore space its rows far enough apart for the marked pixels of one row to leave before the next row is finished. If the rows come closer than that, or if the FIFO fills, pixels are lost and a sticky flag reports the loss.

Top module: `cluster_finder`

## Requirements
- R1: After reset, `out_valid` is 0 and `overflow` is 0.
- R2: A 2×2 group whose top-left pixel is (r, c) covers rows r and r+1 and columns c and c+1. The group is a hit only if the sum of its four samples is strictly greater than `thresh`. A sum equal to `thresh` marks nothing.
- R3: A hit at top-left (r, c) marks every pixel in rows r-3 to r+3 and columns c-3 to c+3. The window is clipped at the array edges, so a hit in the middle marks 49 pixels and a hit at the corner (0,0) marks 16.
- R4: Only marked pixels produce output words. Unmarked pixels are discarded.
- R5: An output word is {row, column, sample}. The sample is in bits [4:0], the column in bits [COL_W+4:5] and the row in the bits above. With the default parameters the word is 13 bits: row [12:9], column [8:5], sample [4:0].
- R6: Words leave in row order, and in ascending column order within a row. A pixel marked by several overlapping windows is written exactly once.
- R7: The rows at the bottom of the frame, including those marked by a hit whose group touches the last row, are emitted without any input after the last row.
- R8: If the FIFO is full when a marked pixel must be written, that pixel is dropped and `overflow` is set. `overflow` stays set until reset, and the words already in the FIFO are delivered unchanged.
- R9: If a row becomes ready for output while the scanner is still emitting an earlier row, all marked pixels of the new row are dropped and `overflow` is set.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh | input | SAMPLE_W+2 | Global threshold for the sum of a 2×2 group |
| row_valid | input | 1 | One row of samples is present on `row_data` |
| row_data | input | NCOLS*SAMPLE_W | Samples of one row; column c is in bits [c*SAMPLE_W +: SAMPLE_W] |
| out_valid | output | 1 | An output word is available |
| out_ready | input | 1 | The reader takes the word this cycle |
| out_data | output | ROW_W+COL_W+SAMPLE_W | Output word {row, column, sample} |
| overflow | output | 1 | Sticky flag: a marked pixel was lost |

## Verification
A single hit in the middle of a noisy background shows the full 49-pixel window, and repeating that hit with its sum lowered to equal the threshold shows that equality does not count as a hit. Hits at opposite corners check the clipping of the window against the edges, and show that the bottom rows are emitted after the frame ends. Two overlapping hits check that pixels covered by both windows are written only once and in row-major order. A stalled reader and a burst of back-to-back rows each force pixels to be lost: the first tells the full-FIFO drop apart from the scanner being busy, and the second shows that only the first finished row survives.

// File: rtl/cluster_finder.sv
module cluster_finder #(
  parameter int NCOLS    = 16,
  parameter int NROWS    = 16,
  parameter int SAMPLE_W = 5,
  parameter int DEPTH    = 8
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic [SAMPLE_W+1:0]                         thresh,
  input  logic                                        row_valid,
  input  logic [NCOLS*SAMPLE_W-1:0]                   row_data,
  output logic                                        out_valid,
  input  logic                                        out_ready,
  output logic [$clog2(NROWS)+$clog2(NCOLS)+SAMPLE_W-1:0] out_data,
  output logic                                        overflow
);
  localparam int COL_W  = $clog2(NCOLS);
  localparam int ROW_W  = $clog2(NROWS);
  localparam int WORD_W = ROW_W + COL_W + SAMPLE_W;
  localparam int SUM_W  = SAMPLE_W + 2;
  localparam int CNT_W  = $clog2(NROWS + 4);
  localparam int AW     = $clog2(DEPTH);
  localparam int ROW_BITS = NCOLS * SAMPLE_W;
  localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(NROWS);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(NROWS + 3);
  localparam logic [CNT_W-1:0] LAG       = CNT_W'(4);
  localparam logic [AW:0]      DEPTH_C   = (AW+1)'(DEPTH);

  logic [CNT_W-1:0]    step_cnt;
  logic [ROW_BITS-1:0] hist [4];
  logic [NCOLS-2:0]    hits [6];
  logic [NCOLS-2:0]    new_hits, vor;
  logic [NCOLS-1:0]    flags;
  logic [NCOLS-1:0]    scan_mask;
  logic [ROW_BITS-1:0] scan_pix;
  logic [ROW_W-1:0]    scan_row;
  logic [COL_W-1:0]    pick;
  logic [WORD_W-1:0]   mem [DEPTH];
  logic [AW-1:0]       wr_ptr, rd_ptr;
  logic [AW:0]         count;

  wire in_frame = step_cnt < FRAME_END;
  wire busy     = |scan_mask;
  wire step     = in_frame ? row_valid : !busy;
  wire emit_row = step && (step_cnt >= LAG);
  wire load     = emit_row && (|flags) && !busy;
  wire drop_row = emit_row && (|flags) && busy;
  wire full     = count == DEPTH_C;
  wire push     = busy && !full;
  wire pop      = out_valid && out_ready;

  always_comb begin
    logic [SUM_W-1:0] s;
    new_hits = '0;
    for (int c = 0; c < NCOLS - 1; c++) begin
      s = SUM_W'(hist[0][c*SAMPLE_W +: SAMPLE_W]) + SUM_W'(hist[0][(c+1)*SAMPLE_W +: SAMPLE_W])
        + SUM_W'(row_data[c*SAMPLE_W +: SAMPLE_W]) + SUM_W'(row_data[(c+1)*SAMPLE_W +: SAMPLE_W]);
      new_hits[c] = in_frame && (step_cnt != '0) && (s > thresh);
    end
  end

  assign vor = new_hits | hits[0] | hits[1] | hits[2] | hits[3] | hits[4] | hits[5];

  always_comb begin
    flags = '0;
    for (int p = 0; p < NCOLS; p++)
      for (int k = 0; k < NCOLS - 1; k++)
        if (k >= p - 3 && k <= p + 3) flags[p] = flags[p] | vor[k];
  end

  always_comb begin
    pick = '0;
    for (int i = NCOLS - 1; i >= 0; i--)
      if (scan_mask[i]) pick = COL_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_cnt <= '0;
      for (int i = 0; i < 4; i++) hist[i] <= '0;
      for (int i = 0; i < 6; i++) hits[i] <= '0;
    end else if (step) begin
      step_cnt <= (step_cnt == LAST_STEP) ? '0 : step_cnt + 1'b1;
      hist[0]  <= in_frame ? row_data : '0;
      for (int i = 1; i < 4; i++) hist[i] <= hist[i-1];
      hits[0]  <= new_hits;
      for (int i = 1; i < 6; i++) hits[i] <= hits[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_mask <= '0;
      scan_pix  <= '0;
      scan_row  <= '0;
      overflow  <= 1'b0;
    end else begin
      if (load) begin
        scan_mask <= flags;
        scan_pix  <= hist[3];
        scan_row  <= ROW_W'(step_cnt - LAG);
      end else if (busy) begin
        scan_mask <= scan_mask & (scan_mask - 1'b1);
      end
      if (drop_row || (busy && full)) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {scan_row, pick, scan_pix[pick*SAMPLE_W +: SAMPLE_W]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign out_valid = count != '0;
  assign out_data  = mem[rd_ptr];

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && full |=> overflow && count == DEPTH_C - (AW+1)'($past(pop)));
  p_dead_time_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_row |=> overflow && $countones(scan_mask) == $countones($past(scan_mask)) - 1);
  p_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);
  p_tail_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame && busy |=> $stable(step_cnt));
endmodule

// File: tb/cluster_finder_tb_top.sv
module cluster_finder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 16;
  localparam int NR = 16;
  localparam int SW = 5;
  localparam int DP = 8;
  localparam int CW = $clog2(NC);
  localparam int RW = $clog2(NR);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SW+1:0] thresh = '0;
  logic row_valid = 1'b0;
  logic [NC*SW-1:0] row_data = '0;
  logic out_valid, out_ready, overflow;
  logic [RW+CW+SW-1:0] out_data;

  int checks = 0, failures = 0, got = 0;
  bit mon_en = 0, done = 0;
  int pix [NR][NC];
  int exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cluster_finder #(.NCOLS(NC), .NROWS(NR), .SAMPLE_W(SW), .DEPTH(DP)) dut_i (
    .clk(clk), .rst_n(rst_n), .thresh(thresh), .row_valid(row_valid), .row_data(row_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .overflow(overflow));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (mon_en && out_valid && out_ready) begin
      int e;
      got++;
      if (exp_q.size() == 0) begin
        check(0, "R4 unexpected word", int'(out_data), -1);
      end else begin
        e = exp_q.pop_front();
        check(int'(out_data >> (CW+SW)) == (e >> (CW+SW)), "R6 row", int'(out_data >> (CW+SW)), e >> (CW+SW));
        check(int'((out_data >> SW) & (NC-1)) == ((e >> SW) & (NC-1)), "R6 column", int'((out_data >> SW) & (NC-1)), (e >> SW) & (NC-1));
        check(int'(out_data & 5'h1f) == (e & 31), "R5 value", int'(out_data & 5'h1f), e & 31);
      end
    end
  end

  task automatic background();
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) pix[r][c] = (r + c) % 4;
  endtask

  task automatic build(input int thr, input int only_row);
    bit mark [NR][NC];
    exp_q.delete();
    for (int r = 0; r < NR; r++) for (int c = 0; c < NC; c++) mark[r][c] = 0;
    for (int r = 0; r < NR - 1; r++)
      for (int c = 0; c < NC - 1; c++)
        if (pix[r][c] + pix[r][c+1] + pix[r+1][c] + pix[r+1][c+1] > thr)
          for (int rr = r - 3; rr <= r + 3; rr++)
            for (int cc = c - 3; cc <= c + 3; cc++)
              if (rr >= 0 && rr < NR && cc >= 0 && cc < NC) mark[rr][cc] = 1;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        if (mark[r][c] && (only_row < 0 || only_row == r))
          exp_q.push_back((r << (CW+SW)) | (c << SW) | pix[r][c]);
  endtask

  task automatic run_frame(input bit contiguous);
    for (int r = 0; r < NR; r++) begin
      tick();
      row_valid = 1'b1;
      for (int c = 0; c < NC; c++) row_data[c*SW +: SW] = SW'(pix[r][c]);
      if (!contiguous) begin
        tick();
        row_valid = 1'b0;
        repeat (20) tick();
      end
    end
    tick();
    row_valid = 1'b0;
    repeat (150) tick();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    out_ready = 1'b1;
    do_reset();
    check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    check(overflow == 0, "R1 overflow after reset", overflow, 0);

    // R3: single mid-array hit, 49 pixels
    thresh = 7'd40;
    background();
    pix[6][6] = 10; pix[6][7] = 10; pix[7][6] = 10; pix[7][7] = 11;
    build(40, -1);
    got = 0; mon_en = 1;
    run_frame(0);
    check(got == 49, "R3 window size", got, 49);
    check(exp_q.size() == 0, "R4 missing words", exp_q.size(), 0);

    // R2: sum equal to threshold gives no hit
    pix[7][7] = 10;
    build(40, -1);
    got = 0;
    run_frame(0);
    check(got == 0, "R2 equal sum no hit", got, 0);

    // R3 and R7: corner hits, bottom rows flushed after frame
    background();
    pix[0][0] = 15; pix[0][1] = 15; pix[1][0] = 15; pix[1][1] = 15;
    pix[NR-2][NC-2] = 15; pix[NR-2][NC-1] = 15; pix[NR-1][NC-2] = 15; pix[NR-1][NC-1] = 15;
    build(40, -1);
    got = 0;
    run_frame(0);
    check(got == 41, "R3 R7 clipped corners", got, 41);
    check(exp_q.size() == 0, "R7 bottom rows emitted", exp_q.size(), 0);

    // R6: overlapping windows, each pixel once
    background();
    pix[5][4] = 11; pix[5][5] = 11; pix[6][4] = 11; pix[6][5] = 11;
    pix[6][6] = 11; pix[6][7] = 11; pix[7][6] = 11; pix[7][7] = 11;
    build(40, -1);
    got = 0;
    run_frame(0);
    check(got == 68, "R6 union of overlapping windows", got, 68);
    check(overflow == 0, "R8 no loss with spaced rows", overflow, 0);

    // R8 and R10: stalled reader fills FIFO
    do_reset();
    background();
    pix[6][6] = 10; pix[6][7] = 10; pix[7][6] = 10; pix[7][7] = 11;
    build(40, -1);
    while (exp_q.size() > DP) void'(exp_q.pop_back());
    out_ready = 1'b0;
    got = 0;
    run_frame(0);
    @(negedge clk);
    check(out_valid == 1, "R10 valid held", out_valid, 1);
    check(int'(out_data) == exp_q[0], "R10 data held", int'(out_data), exp_q[0]);
    repeat (5) @(negedge clk);
    check(int'(out_data) == exp_q[0], "R10 data stable", int'(out_data), exp_q[0]);
    check(overflow == 1, "R8 overflow on full", overflow, 1);
    tick();
    out_ready = 1'b1;
    repeat (40) tick();
    check(got == DP, "R8 kept words", got, DP);
    check(overflow == 1, "R8 overflow sticky", overflow, 1);

    // R9: back-to-back rows, only first finished row survives
    do_reset();
    check(overflow == 0, "R1 overflow cleared", overflow, 0);
    build(40, 3);
    got = 0;
    run_frame(1);
    check(got == 7, "R9 dead time drops rows", got, 7);
    check(overflow == 1, "R9 overflow on dead time", overflow, 1);

    mon_en = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule